// File: doc/BRIEF.md
# Mirrored-Bank Dual-Read Register File

This block is a small general-purpose register file for a pipelined datapath. It has one write port and two read ports. Instead of one storage array with several ports, it holds two identical banks. Each bank has one write port and one read port. Every write goes to both banks with the same address and data, so the banks always hold the same contents. Each read port has its own bank, so two different registers can be read in the same cycle.

A write happens on the rising clock edge when the write enable is high. Reads are combinational. Each read port gives two results. The stored word is the value held before any write in the current cycle. The forwarded word also covers a write to the same address in the current cycle. This lets a decode stage pick either the settled value or the newest value without a second lookup. A synchronous reset clears both banks to zero.

Top module: `rf_mirror2r`

## Requirements
- R1: The file holds 16 registers of 16 bits, selected by a 4-bit address. When `wr_en` is 1 at a rising edge, `wr_data` is stored at `wr_addr`, and a read of that address in any later cycle returns it.
- R2: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_addr` and `wr_data` carry.
- R3: The two read ports are independent. In one cycle, port A returns the register at `rd_a_addr` and port B returns the register at `rd_b_addr`, including when the two addresses differ.
- R4: Both banks hold identical contents at every address at every clock edge. Reading the same address on both ports always gives equal words.
- R5: In a cycle where `wr_en` is 1 and a read address equals `wr_addr`, that port's stored output (`rd_a_data` or `rd_b_data`) returns the value held before the write.
- R6: A port's forwarded output (`rd_a_fwd` or `rd_b_fwd`) equals `wr_data` when `wr_en` is 1 and its read address equals `wr_addr`. Otherwise it equals the port's stored output.
- R7: When `rst` is 1 at a rising edge, every register in both banks becomes zero. Reset takes priority over a write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_a_addr | input | 4 | Read address, port A |
| rd_b_addr | input | 4 | Read address, port B |
| rd_a_data | output | 16 | Port A stored word |
| rd_b_data | output | 16 | Port B stored word |
| rd_a_fwd | output | 16 | Port A word with same-cycle write forwarded |
| rd_b_fwd | output | 16 | Port B word with same-cycle write forwarded |

## Verification
The assertions assume that the inputs are known (not X) at each rising edge outside reset and that every address lies inside the file. With the default depth, every 4-bit code is a valid register. The stimulus changes inputs only on the falling edge. It draws addresses only from the 4-bit range, and write enable and data from a fixed-seed random source. The random traffic includes a bias toward collisions, where a read address matches the write address, so that the forwarding and old-value rules are exercised often.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned RF_DEPTH_DEF = 16;
    localparam int unsigned RF_WIDTH_DEF = 16;
    localparam int unsigned RF_PORTS     = 2;

    typedef enum logic {
        SRC_STORED = 1'b0,
        SRC_WRITE  = 1'b1
    } fwd_src_e;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else if (wr_en && (32'(wr_addr) < DEPTH)) begin
            st_d.regs[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_addr) < DEPTH) begin
            rd_data = st_q.regs[rd_addr];
        end
    end

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (32'(wr_addr) < DEPTH)) |=> (st_q.regs[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/rf_fwd.sv
module rf_fwd #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] fwd
);
    rf_pkg::fwd_src_e src;

    always_comb begin
        src = rf_pkg::SRC_STORED;
        if (wr_en && (rd_addr == wr_addr)) begin
            src = rf_pkg::SRC_WRITE;
        end
        fwd = (src == rf_pkg::SRC_WRITE) ? wr_data : stored;
    end
endmodule

// File: rtl/rf_mirror2r.sv
module rf_mirror2r #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH_DEF,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH_DEF,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned NP   = rf_pkg::RF_PORTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_a_addr,
    input  logic [AW-1:0]    rd_b_addr,
    output logic [WIDTH-1:0] rd_a_data,
    output logic [WIDTH-1:0] rd_b_data,
    output logic [WIDTH-1:0] rd_a_fwd,
    output logic [WIDTH-1:0] rd_b_fwd
);
    logic [NP-1:0][AW-1:0]    port_addr;
    logic [NP-1:0][WIDTH-1:0] port_data;
    logic [NP-1:0][WIDTH-1:0] port_fwd;

    assign port_addr[0] = rd_a_addr;
    assign port_addr[1] = rd_b_addr;

    for (genvar p = 0; p < NP; p++) begin : gen_port
        rf_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (port_addr[p]),
            .rd_data (port_data[p])
        );

        rf_fwd #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fwd (
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (port_addr[p]),
            .stored  (port_data[p]),
            .fwd     (port_fwd[p])
        );
    end

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];
    assign rd_a_fwd  = port_fwd[0];
    assign rd_b_fwd  = port_fwd[1];

    for (genvar i = 0; i < DEPTH; i++) begin : gen_mirror
        // R4
        bank_mirror_chk: assert property (@(posedge clk) disable iff (rst)
            gen_port[0].u_bank.st_q.regs[i] == gen_port[1].u_bank.st_q.regs[i]);
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(rd_a_addr) -> $stable(rd_a_data)));

    // R6
    fwd_predicts_a_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ($stable(rd_a_addr) -> (rd_a_data == $past(rd_a_fwd))));

    // R6
    fwd_predicts_b_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ($stable(rd_b_addr) -> (rd_b_data == $past(rd_b_fwd))));
endmodule

// File: tb/test_rf_mirror2r.sv
module test_rf_mirror2r;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr, rd_a_addr, rd_b_addr;
    logic [15:0] wr_data;
    logic [15:0] rd_a_data, rd_b_data, rd_a_fwd, rd_b_fwd;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [15:0] model [16];

    always #2 clk = ~clk;

    rf_mirror2r i_rf_mirror2r (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .rd_a_fwd(rd_a_fwd), .rd_b_fwd(rd_b_fwd)
    );

    function automatic logic [15:0] exp_fwd(logic [3:0] ra);
        return (wr_en && (ra == wr_addr)) ? wr_data : model[ra];
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ports(string req);
        chk(req, rd_a_data, model[rd_a_addr]);
        chk(req, rd_b_data, model[rd_b_addr]);
        chk({req, "/R6"}, rd_a_fwd, exp_fwd(rd_a_addr));
        chk({req, "/R6"}, rd_b_fwd, exp_fwd(rd_b_addr));
    endtask

    // drive at falling edge, check before rising edge, then advance model
    task automatic step(logic r, logic we, logic [3:0] wa, logic [15:0] wd,
                        logic [3:0] ra, logic [3:0] rb, string req);
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #1;
        if (!r) check_ports(req);
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 16; k++) model[k] = '0;
        end else if (we) begin
            model[wa] = wd;
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0;
        for (int k = 0; k < 16; k++) model[k] = '0;
        step(1, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 0, 0, 0, "R7");
        // R7: all zero after reset
        for (int k = 0; k < 16; k += 2) step(0, 0, 0, 16'hFFFF, 4'(k), 4'(k + 1), "R7");
        // R1: fill every register, R3: read differing pairs
        for (int k = 0; k < 16; k++) step(0, 1, 4'(k), 16'hA500 ^ 16'(k * 16'h0111), 4'(15 - k), 4'(k), "R1");
        for (int k = 0; k < 16; k++) step(0, 0, 0, 0, 4'(k), 4'(15 - k), "R3");
        // R4: same address on both ports
        for (int k = 0; k < 16; k++) begin
            step(0, 0, 0, 0, 4'(k), 4'(k), "R4");
            chk("R4", rd_a_data, rd_b_data);
        end
        // R2: idle cycles with junk on write inputs
        step(0, 0, 4'd3, 16'hDEAD, 4'd3, 4'd3, "R2");
        step(0, 0, 4'd3, 16'hBEEF, 4'd3, 4'd0, "R2");
        chk("R2", rd_a_data, 16'hA500 ^ 16'h0333);
        // R5: collision returns old value, forwarded gives new
        step(0, 1, 4'd15, 16'h1234, 4'd15, 4'd15, "R5");
        step(0, 0, 0, 0, 4'd15, 4'd0, "R5");
        chk("R1", rd_a_data, 16'h1234);
        step(0, 1, 4'd0, 16'hFFFF, 4'd0, 4'd1, "R5");
        // R7: reset wins over write
        step(1, 1, 4'd5, 16'h7777, 0, 0, "R7");
        step(0, 0, 0, 0, 4'd5, 4'd15, "R7");
        chk("R7", rd_a_data, 16'h0000);
        // random traffic with collision bias
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] wa = 4'($urandom_range(0, 15));
            logic [3:0] ra = ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15));
            logic [3:0] rb = ($urandom_range(0, 3) == 0) ? wa : 4'($urandom_range(0, 15));
            logic       r  = ($urandom_range(0, 499) == 0);
            step(r, 1'($urandom_range(0, 1)), wa, 16'($urandom), ra, rb,
                 (ra == wa || rb == wa) ? "R5" : "R3");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule